// File: doc/BRIEF.md
# Disk controller status register unit

This block supplies the three read-only status registers of a floppy-style disk controller's host interface. They sit at register offsets 0, 1 and 7. The block takes the drive-interface signals, which arrive asynchronously, and brings them into the core clock domain. It also keeps a small set of edge-driven flip-flops: two toggles and four sticky latches. From these it builds the byte that the host reads.

A 2-bit personality input picks one of three layouts:

- **AT:** offsets 0 and 1 are not driven at all, and offset 7 drives only its top bit.
- **PS/2:** the drive-interface levels appear at offset 0, mostly active-low. Offset 1 carries toggle bits and sideband state.
- **Model 30:** offset 0 uses the opposite polarities and replaces the live step level with a latched one. Offset 1 shows the latched write-gate, read-data and write-data events.

The host drives a one-cycle qualified read strobe together with an offset. The block answers in the same cycle with a data byte and a per-bit output enable. A strobed read of offset 7 clears the sticky latches, so each event is reported once. The data-rate, precompensation, DMA-enable, motor-enable and drive-select values come in as sideband levels from the neighbouring control registers.

Top module: `dskstat_unit`

## Requirements
- R1: `rd_oe` and `rd_data` are both 0 in two cases: when `rd_stb` is low, and when the strobed offset is one of 2 to 6. Any `rd_data` bit whose `rd_oe` bit is 0 reads 0.
- R2: With `mode` = 0 (AT), a strobed read of offset 0 or 1 drives nothing. A strobed read of offset 7 drives only bit 7 (`rd_oe` = 8'h80).
- R3: PS/2 offset 0 (`mode` = 1) is a fully driven byte:
  - bit 7: interrupt
  - bit 6: 1
  - bit 5: live step level
  - bit 4: inverted track-0
  - bit 3: head select
  - bit 2: inverted index
  - bit 1: inverted write-protect
  - bit 0: direction
- R4: Model 30 offset 0 (`mode` = 2) is a fully driven byte:
  - bit 7: interrupt
  - bit 6: DMA request
  - bit 5: step latch
  - bit 4: track-0
  - bit 3: inverted head select
  - bit 2: index
  - bit 1: write-protect
  - bit 0: inverted direction
- R5: PS/2 offset 1 is a fully driven byte:
  - bits 7:6: 2'b11
  - bit 5: `dor_dsel0`
  - bit 4: write-data toggle
  - bit 3: read-data toggle
  - bit 2: live write-gate level
  - bits 1:0: `dor_mot`

  Each toggle inverts on every falling edge of its input.
- R6: Model 30 offset 1 is a fully driven byte:
  - bits 7:6: 1
  - bit 5: `dor_dsel0`
  - bit 4: write-data latch, set on a falling edge
  - bit 3: read-data latch, set on a falling edge
  - bit 2: write-gate latch, set on a rising edge
  - bits 1:0: 1

  The write-data latch is set whatever the write-gate level.
- R7: A strobed read of offset 7 clears the four latches (step, write gate, read data, write data) at the next clock edge. If a set event for a latch arrives at that same edge, that latch is set instead. Reads of any other offset clear nothing.
- R8: `sw_rst` clears the step latch at the next edge, and this overrides a step set event. It leaves the toggles, the other three latches and the `dor_mot`/`dor_dsel0` bits unchanged. `rst_n` low clears every toggle and latch.
- R9: Offset 7 bit 7 equals `frc_chg_val` when `frc_chg_en` is 1. Otherwise it is the inverse of the synchronised disk-change pin.
- R10: PS/2 offset 7 is a fully driven byte:
  - bit 7: disk change (R9)
  - bits 6:3: 4'b1111
  - bits 2:1: `rate_sel`
  - bit 0: 1 for `rate_sel` 01 or 10 (300 or 250 kbps), 0 for 00 or 11 (500 kbps or 1 Mbps)
- R11: Model 30 offset 7 is a fully driven byte:
  - bit 7: disk change (R9)
  - bits 6:4: 0
  - bit 3: `dor_dmaen`
  - bit 2: `noprec`
  - bits 1:0: `rate_sel`
- R12: Level changes on `drv_sig` show in the read view after two clock edges. Edge-driven toggles and latches change after three edges. `drv_sig` bit order:

  | Bit | Signal |
  |-----|--------|
  | 0 | read data |
  | 1 | write data |
  | 2 | step |
  | 3 | write gate |
  | 4 | direction (1 = inward) |
  | 5 | write-protect (1 = protected) |
  | 6 | index |
  | 7 | head select (1 = side 1) |
  | 8 | track-0 (1 = at track 0) |
  | 9 | interrupt |
  | 10 | DMA request |
  | 11 | disk-change pin, active low |

- R13: `mode` = 3 behaves exactly like AT mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset level from the output control register |
| mode | input | 2 | Personality: 0 AT, 1 PS/2, 2 Model 30, 3 as AT |
| rd_stb | input | 1 | Qualified one-cycle read strobe |
| rd_addr | input | 3 | Register offset of the read |
| rd_data | output | 8 | Read data, valid while `rd_stb` is high |
| rd_oe | output | 8 | Per-bit drive enable for `rd_data` |
| drv_sig | input | 12 | Asynchronous drive-interface signals, bit order in R12 |
| dor_mot | input | 2 | Motor enables 1:0 |
| dor_dsel0 | input | 1 | Drive-select bit 0 |
| dor_dmaen | input | 1 | DMA enable bit |
| rate_sel | input | 2 | Selected data-rate code |
| noprec | input | 1 | No-precompensation bit |
| frc_chg_en | input | 1 | Force the disk-change status |
| frc_chg_val | input | 1 | Disk-change value used when forced |

## Verification
The hardest case to reach from the ports is a read of offset 7 that lands on exactly the edge where a new latch event becomes visible. The event only appears there after the synchroniser and edge stages have passed it along, so the collision needs precise timing. The stimulus raises write gate on one falling clock edge and places the offset-7 strobe two falling edges later, which makes both fall on the same rising edge. A second directed case holds `sw_rst` high while a step edge matures. Random sweeps through all four mode codes cover the layouts and polarities, and a behavioural reference with a history queue predicts every cycle.

// File: rtl/dskstat_pkg.sv
`timescale 1ns/1ps
package dskstat_pkg;
  typedef enum logic [1:0] {
    MODE_AT  = 2'd0,
    MODE_PS2 = 2'd1,
    MODE_M30 = 2'd2,
    MODE_RSV = 2'd3
  } pmode_e;

  localparam int REG_W  = 8;
  localparam int NSIG   = 12;
  localparam int EDGE_W = 4;            // signals that carry edge events sit at the bottom
  localparam int LVL_LO = 2;            // lowest signal whose level is shown to the host

  // drive-interface bit positions
  localparam int SIG_RDAT = 0;
  localparam int SIG_WDAT = 1;
  localparam int SIG_STEP = 2;
  localparam int SIG_WGAT = 3;
  localparam int SIG_DIR  = 4;
  localparam int SIG_WP   = 5;
  localparam int SIG_IDX  = 6;
  localparam int SIG_HEAD = 7;
  localparam int SIG_TRK0 = 8;
  localparam int SIG_INT  = 9;
  localparam int SIG_DRQ  = 10;
  localparam int SIG_CHGN = 11;

  // event polarity per edge signal: 1 = falling edge, 0 = rising edge
  localparam logic [EDGE_W-1:0] FALL_MASK = 4'b0011;

  localparam logic [2:0] OFS_A = 3'd0;
  localparam logic [2:0] OFS_B = 3'd1;
  localparam logic [2:0] OFS_D = 3'd7;

  // density flag: high for the two slow rates (codes 01 and 10)
  function automatic logic density_n(input logic [1:0] rate);
    return (rate == 2'b01) || (rate == 2'b10);
  endfunction

  // disk-change status bit: forced value or inverted pin
  function automatic logic chg_status(input logic pin_n, input logic frc_en, input logic frc_val);
    return frc_en ? frc_val : ~pin_n;
  endfunction
endpackage

// File: rtl/dskstat_sync.sv
`timescale 1ns/1ps
module dskstat_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2,
  parameter int EDGE_W = 4,
  parameter int LVL_LO = 2,
  parameter logic [EDGE_W-1:0] FALL_MASK = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIDTH-1:0]        async_i,
  output logic [WIDTH-1:LVL_LO]   lvl_o,
  output logic [EDGE_W-1:0]       ev_o
);
  logic [WIDTH-1:0]  chain [STAGES];
  logic [EDGE_W-1:0] prev_q;
  logic [WIDTH-1:0]  synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[STAGES-1][EDGE_W-1:0];
    end
  end

  assign synced = chain[STAGES-1];
  assign lvl_o  = synced[WIDTH-1:LVL_LO];

  for (genvar g = 0; g < EDGE_W; g++) begin : g_edge
    if (FALL_MASK[g]) begin : g_fall
      assign ev_o[g] = ~synced[g] & prev_q[g];
    end else begin : g_rise
      assign ev_o[g] = synced[g] & ~prev_q[g];
    end
  end
endmodule

// File: rtl/dskstat_flags.sv
`timescale 1ns/1ps
module dskstat_flags #(
  parameter int EDGE_W   = 4,
  parameter int STEP_IDX = 2,
  parameter int TOG_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              rd_clr,
  input  logic [EDGE_W-1:0] ev_i,
  output logic [EDGE_W-1:0] lat_q,
  output logic [TOG_W-1:0]  tog_q
);
  // sticky latches: one per edge signal
  for (genvar g = 0; g < EDGE_W; g++) begin : g_lat
    if (g == STEP_IDX) begin : g_step
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_q[g] <= 1'b0;
        else if (sw_rst)  lat_q[g] <= 1'b0;
        else if (ev_i[g]) lat_q[g] <= 1'b1;
        else if (rd_clr)  lat_q[g] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_q[g] <= 1'b0;
        else if (ev_i[g]) lat_q[g] <= 1'b1;
        else if (rd_clr)  lat_q[g] <= 1'b0;
      end
    end
  end

  // toggles driven by the lowest TOG_W events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= '0;
    else        tog_q <= tog_q ^ ev_i[TOG_W-1:0];
  end
endmodule

// File: rtl/dskstat_unit.sv
`timescale 1ns/1ps
module dskstat_unit
  import dskstat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic [1:0]       mode,
  input  logic             rd_stb,
  input  logic [2:0]       rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] rd_oe,
  input  logic [NSIG-1:0]  drv_sig,
  input  logic [1:0]       dor_mot,
  input  logic             dor_dsel0,
  input  logic             dor_dmaen,
  input  logic [1:0]       rate_sel,
  input  logic             noprec,
  input  logic             frc_chg_en,
  input  logic             frc_chg_val
);
  localparam int TOG_W = 2;

  logic [NSIG-1:LVL_LO] lv;
  logic [EDGE_W-1:0]    ev_hit;
  logic [EDGE_W-1:0]    lat_q;
  logic [TOG_W-1:0]     tog_q;
  logic                 rd_clr;
  pmode_e               pm;
  logic                 is_ps2, is_m30, chg_v;
  logic [REG_W-1:0]     va_ps2, va_m30, vb_ps2, vb_m30, vd_ps2, vd_m30;
  logic [REG_W-1:0]     dat_c, oe_c;

  dskstat_sync #(
    .WIDTH(NSIG), .STAGES(SYNC_STAGES), .EDGE_W(EDGE_W),
    .LVL_LO(LVL_LO), .FALL_MASK(FALL_MASK)
  ) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(drv_sig), .lvl_o(lv), .ev_o(ev_hit)
  );

  assign rd_clr = rd_stb && (rd_addr == OFS_D);

  dskstat_flags #(
    .EDGE_W(EDGE_W), .STEP_IDX(SIG_STEP), .TOG_W(TOG_W)
  ) flags_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rd_clr(rd_clr),
    .ev_i(ev_hit), .lat_q(lat_q), .tog_q(tog_q)
  );

  assign pm     = pmode_e'(mode);
  assign is_ps2 = (pm == MODE_PS2);
  assign is_m30 = (pm == MODE_M30);
  assign chg_v  = chg_status(lv[SIG_CHGN], frc_chg_en, frc_chg_val);

  // offset 0 views
  assign va_ps2 = {lv[SIG_INT], 1'b1, lv[SIG_STEP], ~lv[SIG_TRK0],
                   lv[SIG_HEAD], ~lv[SIG_IDX], ~lv[SIG_WP], lv[SIG_DIR]};
  assign va_m30 = {lv[SIG_INT], lv[SIG_DRQ], lat_q[SIG_STEP], lv[SIG_TRK0],
                   ~lv[SIG_HEAD], lv[SIG_IDX], lv[SIG_WP], ~lv[SIG_DIR]};
  // offset 1 views
  assign vb_ps2 = {2'b11, dor_dsel0, tog_q[SIG_WDAT], tog_q[SIG_RDAT],
                   lv[SIG_WGAT], dor_mot};
  assign vb_m30 = {2'b11, dor_dsel0, lat_q[SIG_WDAT], lat_q[SIG_RDAT],
                   lat_q[SIG_WGAT], 2'b11};
  // offset 7 views
  assign vd_ps2 = {chg_v, 4'b1111, rate_sel, density_n(rate_sel)};
  assign vd_m30 = {chg_v, 3'b000, dor_dmaen, noprec, rate_sel};

  always_comb begin
    dat_c = '0;
    oe_c  = '0;
    if (rd_stb) begin
      case (rd_addr)
        OFS_A: begin
          if (is_ps2)      begin oe_c = '1; dat_c = va_ps2; end
          else if (is_m30) begin oe_c = '1; dat_c = va_m30; end
        end
        OFS_B: begin
          if (is_ps2)      begin oe_c = '1; dat_c = vb_ps2; end
          else if (is_m30) begin oe_c = '1; dat_c = vb_m30; end
        end
        OFS_D: begin
          if (is_ps2)      begin oe_c = '1; dat_c = vd_ps2; end
          else if (is_m30) begin oe_c = '1; dat_c = vd_m30; end
          else begin
            oe_c  = {1'b1, {(REG_W-1){1'b0}}};
            dat_c = {chg_v, {(REG_W-1){1'b0}}};
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_data = dat_c;
  assign rd_oe   = oe_c;
endmodule

// File: rtl/dskstat_chk.sv
`timescale 1ns/1ps
module dskstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic [1:0] mode,
  input logic       rd_stb,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [7:0] rd_oe,
  input logic       rd_clr,
  input logic [3:0] ev_hit,
  input logic [3:0] lat_q,
  input logic [1:0] tog_q
);
  logic at_like;
  assign at_like = (mode == 2'd0) || (mode == 2'd3);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> (rd_oe == 8'h00 && rd_data == 8'h00));

  assert_at_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && at_like && rd_addr != 3'd7) |-> rd_oe == 8'h00);

  assert_at_chg_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && at_like && rd_addr == 3'd7) |-> (rd_oe == 8'h80 && rd_data[6:0] == 7'h00));

  assert_fixed_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == 2'd1 && rd_addr == 3'd1) |-> rd_data[7:6] == 2'b11);

  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit[0] |=> tog_q[0] != $past(tog_q[0]));

  assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hit[1] |=> $stable(tog_q[1]));

  assert_clear_wgate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !ev_hit[3]) |=> !lat_q[3]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit[0] |=> lat_q[0]);

  assert_step_swrst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !lat_q[2]);
endmodule

bind dskstat_unit dskstat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode(mode), .rd_stb(rd_stb),
  .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe), .rd_clr(rd_clr),
  .ev_hit(ev_hit), .lat_q(lat_q), .tog_q(tog_q)
);

// File: tb/dskstat_unit_tb.sv
`timescale 1ns/1ps
module dskstat_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst_n, sw_rst, rd_stb, dor_dsel0, dor_dmaen, noprec, frc_chg_en, frc_chg_val;
  logic [1:0]  mode, dor_mot, rate_sel;
  logic [2:0]  rd_addr;
  logic [11:0] drv_sig;
  logic [7:0]  rd_data, rd_oe;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string phase  = "R1 reset";

  dskstat_unit dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode(mode), .rd_stb(rd_stb),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_oe(rd_oe), .drv_sig(drv_sig),
    .dor_mot(dor_mot), .dor_dsel0(dor_dsel0), .dor_dmaen(dor_dmaen),
    .rate_sel(rate_sel), .noprec(noprec), .frc_chg_en(frc_chg_en),
    .frc_chg_val(frc_chg_val)
  );

  // ---------------- behavioural reference ----------------
  // hist holds the pin vectors seen at the last three rising edges, oldest first
  logic [11:0] hist[$];
  logic [11:0] m_now, m_old;
  bit tg_rd, tg_wd, lt_rd, lt_wd, lt_step, lt_wg, m_clr;

  task automatic model_clear();
    hist.delete();
    repeat (3) hist.push_back(12'h000);
    tg_rd = 0; tg_wd = 0; lt_rd = 0; lt_wd = 0; lt_step = 0; lt_wg = 0;
  endtask

  initial model_clear();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      m_now = hist[1];
      m_old = hist[0];
      m_clr = rd_stb && (rd_addr == 3'd7);
      // read data: falling edge flips the toggle and sets the latch
      if (!m_now[0] && m_old[0]) begin tg_rd = !tg_rd; lt_rd = 1; end
      else if (m_clr) lt_rd = 0;
      if (!m_now[1] && m_old[1]) begin tg_wd = !tg_wd; lt_wd = 1; end
      else if (m_clr) lt_wd = 0;
      if (sw_rst) lt_step = 0;
      else if (m_now[2] && !m_old[2]) lt_step = 1;
      else if (m_clr) lt_step = 0;
      if (m_now[3] && !m_old[3]) lt_wg = 1;
      else if (m_clr) lt_wg = 0;
      hist.push_back(drv_sig);
      void'(hist.pop_front());
    end
  end

  task automatic check_now();
    logic [7:0]  ed, eo;
    logic [11:0] s;
    string       req;
    bit          at, chg;
    s   = hist[2 - 1];
    ed  = 8'h00;
    eo  = 8'h00;
    at  = (mode == 2'd0) || (mode == 2'd3);
    req = "R1";
    chg = frc_chg_en ? frc_chg_val : !s[11];
    if (rd_stb) begin
      if (rd_addr == 3'd0 && !at) begin
        eo = 8'hFF;
        if (mode == 2'd1) begin
          req = "R3";
          ed[0] = s[4];  ed[1] = !s[5]; ed[2] = !s[6]; ed[3] = s[7];
          ed[4] = !s[8]; ed[5] = s[2];  ed[6] = 1'b1;  ed[7] = s[9];
        end else begin
          req = "R4";
          ed[0] = !s[4]; ed[1] = s[5];  ed[2] = s[6];   ed[3] = !s[7];
          ed[4] = s[8];  ed[5] = lt_step; ed[6] = s[10]; ed[7] = s[9];
        end
      end else if (rd_addr == 3'd1 && !at) begin
        eo = 8'hFF;
        if (mode == 2'd1) begin
          req = "R5";
          ed[1:0] = dor_mot; ed[2] = s[3]; ed[3] = tg_rd; ed[4] = tg_wd;
          ed[5] = dor_dsel0; ed[7:6] = 2'b11;
        end else begin
          req = "R6";
          ed = 8'b1100_0011;
          ed[2] = lt_wg; ed[3] = lt_rd; ed[4] = lt_wd; ed[5] = dor_dsel0;
        end
      end else if (rd_addr == 3'd7) begin
        if (at) begin
          req = "R9"; eo = 8'h80; ed[7] = chg;
        end else if (mode == 2'd1) begin
          req = "R10"; eo = 8'hFF;
          ed = {chg, 4'hF, rate_sel, (rate_sel[0] ^ rate_sel[1])};
        end else begin
          req = "R11"; eo = 8'hFF;
          ed = {chg, 3'b000, dor_dmaen, noprec, rate_sel};
        end
      end else if (at && rd_addr <= 3'd1) req = "R2";
    end
    checks++;
    if (rd_oe !== eo || rd_data !== ed) begin
      fails++;
      $display("FAIL %s [%s] mode=%0d ofs=%0d: data=%h oe=%h expected data=%h oe=%h",
               req, phase, mode, rd_addr, rd_data, rd_oe, ed, eo);
    end
  endtask

  // compare one nanosecond before every rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (!done) check_now();
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      done = 1;
      report();
      $finish;
    end
  end

  task automatic idle_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_at(input logic [2:0] ofs);
    rd_addr = ofs; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  initial begin
    rst_n = 0; sw_rst = 0; rd_stb = 0; rd_addr = 0; mode = 2'd1;
    drv_sig = 12'h000; dor_mot = 0; dor_dsel0 = 0; dor_dmaen = 0;
    rate_sel = 2'b10; noprec = 0; frc_chg_en = 0; frc_chg_val = 0;
    // R1 reset: strobed reads during reset show cleared state
    idle_cyc(2);
    rd_stb = 1; rd_addr = 3'd1;
    idle_cyc(1);
    rd_addr = 3'd7;
    idle_cyc(1);
    rd_stb = 0;
    rst_n = 1;
    idle_cyc(3);

    // R13 sweep over every mode code, random pins, sideband and reads
    for (int m = 0; m < 4; m++) begin
      phase = $sformatf("R13 mode %0d sweep", m);
      mode = m[1:0];
      for (int c = 0; c < 300; c++) begin
        drv_sig     = 12'($urandom);
        dor_mot     = 2'($urandom);
        dor_dsel0   = 1'($urandom);
        dor_dmaen   = 1'($urandom);
        rate_sel    = 2'($urandom);
        noprec      = 1'($urandom);
        frc_chg_en  = ($urandom % 4) == 0;
        frc_chg_val = 1'($urandom);
        sw_rst      = ($urandom % 16) == 0;
        rd_stb      = ($urandom % 3) != 0;
        case ($urandom % 4)
          0: rd_addr = 3'd0;
          1: rd_addr = 3'd1;
          2: rd_addr = 3'd7;
          default: rd_addr = 3'($urandom);
        endcase
        idle_cyc(1);
      end
    end
    rd_stb = 0; sw_rst = 0; frc_chg_en = 0;

    // R12 latency: a direction change seen in Model 30 offset 0
    phase = "R12 latency";
    mode = 2'd2; drv_sig = 12'h000;
    idle_cyc(4);
    rd_stb = 1; rd_addr = 3'd0;
    drv_sig[4] = 1'b1;
    idle_cyc(4);
    rd_stb = 0;

    // R6 latches, then R7 clear by offset-7 read and no clear from offset 1
    phase = "R6 latch set";
    drv_sig[3] = 1; idle_cyc(1);
    drv_sig[0] = 1; drv_sig[1] = 1; idle_cyc(2);
    drv_sig[0] = 0; drv_sig[1] = 0; drv_sig[3] = 0; idle_cyc(4);
    phase = "R7 offset-1 read keeps latches";
    read_at(3'd1); read_at(3'd1);
    phase = "R7 offset-7 read clears";
    read_at(3'd7); read_at(3'd1);

    // R7 collision: write gate rises, offset-7 strobe lands on the set edge
    phase = "R7 collision";
    drv_sig[3] = 1;
    idle_cyc(2);
    read_at(3'd7);
    read_at(3'd1);
    drv_sig[3] = 0; idle_cyc(4);

    // R8 software reset: step latch cleared and beats a step edge; toggles kept
    phase = "R8 software reset";
    mode = 2'd2;
    drv_sig[2] = 1; idle_cyc(4);
    read_at(3'd0);
    drv_sig[2] = 0; idle_cyc(3);
    drv_sig[2] = 1; sw_rst = 1; idle_cyc(4);
    sw_rst = 0;
    read_at(3'd0);
    mode = 2'd1; dor_mot = 2'b11; dor_dsel0 = 1; sw_rst = 1;
    read_at(3'd1);
    sw_rst = 0;

    // R9 forced disk change in AT mode
    phase = "R9 forced change";
    mode = 2'd0; frc_chg_en = 1; frc_chg_val = 0;
    read_at(3'd7);
    frc_chg_val = 1; read_at(3'd7);
    frc_chg_en = 0; drv_sig[11] = 1; idle_cyc(3); read_at(3'd7);

    // R10 density flag for every rate code
    phase = "R10 rate codes";
    mode = 2'd1;
    for (int r = 0; r < 4; r++) begin rate_sel = r[1:0]; read_at(3'd7); end
    // R11 Model 30 offset 7
    phase = "R11 rate codes";
    mode = 2'd2; noprec = 1; dor_dmaen = 1;
    for (int r = 0; r < 4; r++) begin rate_sel = r[1:0]; read_at(3'd7); end

    // R1 offsets without a register
    phase = "R1 empty offsets";
    for (int a = 2; a < 7; a++) read_at(a[2:0]);

    idle_cyc(2);
    done = 1;
    report();
    $finish;
  end
endmodule